// File: doc/BRIEF.md
# Sprite vertical hit checker

This block decides, one request at a time, whether a scanline crosses the rows covered by a sprite. A request carries the sprite's top coordinate and the scanline coordinate. The answer is a visibility flag and a row offset. The offset is the byte position of the hit row inside the sprite's pixel data, so a fetch unit can use it directly.

Requests enter and answers leave through valid/ready handshakes. A clock enable gates the whole pipeline. The datapath has two registered stages. The first forms the scanline-minus-top difference with one extra bit, so a scanline above the sprite can never wrap into a hit. The second tests that difference against the sprite height and turns the row number into an offset from a constant table.

The coordinate width, the sprite height, the bytes per row and the offset width are parameters. A parameter chooses whether the offsets come from a table or from a constant multiply.

Top module: `sprite_vhit_check`

## Requirements
- R1: An answer reports visible exactly when top <= line < top + SPR_ROWS, with both values taken as unsigned integers; a sprite whose rows run past the largest coordinate is still handled correctly (for example top 1008 at scanline 1023 with 16 rows and 10 bits).
- R2: When the scanline is smaller than the sprite top, the answer is not visible. The difference never wraps (for example scanline 0, top 1).
- R3: When visible, `out_offset` equals (line - top) * ROW_BYTES. Row 0 gives 0.
- R4: When not visible, `out_offset` is 0.
- R5: Every request accepted (a clock edge with `in_valid`, `in_ready` and `ce` all high) yields exactly one answer, in acceptance order. An answer is consumed on an edge with `out_valid`, `out_ready` and `ce` all high.
- R6: While `out_valid` is high and the answer is not consumed, `out_valid`, `out_visible` and `out_offset` hold their values.
- R7: `in_ready` is low whenever `out_valid` is high and `out_ready` is low.
- R8: While `ce` is low, `in_ready` is low and no output changes on the next edge.
- R9: During reset, `out_valid` is low. With `ce` high, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Clock enable for every register |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this edge |
| spr_top | input | COORD_W | Sprite top coordinate |
| scan_line | input | COORD_W | Scanline coordinate |
| out_ready | input | 1 | Consumer takes the answer |
| out_valid | output | 1 | Answer present |
| out_visible | output | 1 | Scanline lies inside the sprite |
| out_offset | output | OFS_W | Row offset, 0 when not visible |

## Verification
The bench builds two copies of the block. The first is a 6-bit, 5-row, 3-bytes-per-row copy on the table path. Every one of its 4096 top/scanline pairs goes through it, so every wrap case, every edge of the top range and a row count that is not a power of two are all covered. The second copy uses the default 10-bit, 16-row, 4-byte configuration on the multiplier path. It takes the coordinates that sit right at the limits of the space, plus random pairs clustered around the sprite rows. Random gaps in the input, random backpressure and random clock-enable drops run throughout, so the handshake rules are tested while answers are stalled.

// File: rtl/sprite_vhit_pkg.sv
package sprite_vhit_pkg;

   // Byte position of a given sprite row inside its pixel data
   function automatic int unsigned row_to_offset(input int unsigned row,
                                                 input int unsigned bytes);
      return row * bytes;
   endfunction

   // Index width able to address n rows (at least 1 bit)
   function automatic int unsigned row_index_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/vhit_diff_stage.sv
module vhit_diff_stage #(
   parameter int COORD_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ce,
   input  logic               take,
   output logic               stage_ready,
   input  logic [COORD_W-1:0] spr_top,
   input  logic [COORD_W-1:0] scan_line,
   output logic               diff_valid,
   output logic [COORD_W:0]   diff,
   input  logic               down_ready
);

   logic               v_q;
   logic [COORD_W:0]   diff_q;
   logic [COORD_W:0]   diff_d;

   // Extra top bit turns into a borrow flag when line < top
   assign diff_d      = {1'b0, scan_line} - {1'b0, spr_top};
   assign stage_ready = !v_q || down_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         diff_q <= '0;
      end else if (ce && stage_ready) begin
         v_q <= take;
         if (take) begin
            diff_q <= diff_d;
         end
      end
   end

   assign diff_valid = v_q;
   assign diff       = diff_q;

endmodule

// File: rtl/vhit_range_stage.sv
module vhit_range_stage
   import sprite_vhit_pkg::*;
#(
   parameter int COORD_W      = 10,
   parameter int SPR_ROWS     = 16,
   parameter int ROW_BYTES    = 4,
   parameter int OFS_W        = 8,
   parameter bit OFS_BY_TABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             diff_valid,
   input  logic [COORD_W:0] diff,
   output logic             stage_ready,
   output logic             res_valid,
   output logic             res_visible,
   output logic [OFS_W-1:0] res_offset,
   input  logic             down_ready
);

   localparam int ROW_W   = row_index_bits(SPR_ROWS);
   localparam int TBL_LEN = 1 << ROW_W;

   logic             hit;
   logic [ROW_W-1:0] row;
   logic [OFS_W-1:0] row_ofs;
   logic             v_q;
   logic             vis_q;
   logic [OFS_W-1:0] ofs_q;

   // Borrow bit clear and magnitude below the height means a hit
   assign hit = !diff[COORD_W] &&
                ({1'b0, diff[COORD_W-1:0]} < (COORD_W+1)'(SPR_ROWS));
   assign row = diff[ROW_W-1:0];

   generate
      if (OFS_BY_TABLE) begin : g_table
         logic [OFS_W-1:0] ofs_tbl [TBL_LEN];
         for (genvar g = 0; g < TBL_LEN; g++) begin : g_entry
            if (g < SPR_ROWS) begin : g_used
               assign ofs_tbl[g] = OFS_W'(row_to_offset(g, ROW_BYTES));
            end else begin : g_spare
               assign ofs_tbl[g] = '0;
            end
         end
         assign row_ofs = ofs_tbl[row];
      end else begin : g_mult
         assign row_ofs = OFS_W'(int'(row) * ROW_BYTES);
      end
   endgenerate

   assign stage_ready = !v_q || down_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         vis_q <= 1'b0;
         ofs_q <= '0;
      end else if (ce && stage_ready) begin
         v_q <= diff_valid;
         if (diff_valid) begin
            vis_q <= hit;
            ofs_q <= hit ? row_ofs : '0;
         end
      end
   end

   assign res_valid   = v_q;
   assign res_visible = vis_q;
   assign res_offset  = ofs_q;

endmodule

// File: rtl/sprite_vhit_check.sv
module sprite_vhit_check
   import sprite_vhit_pkg::*;
#(
   parameter int COORD_W      = 10,
   parameter int SPR_ROWS     = 16,
   parameter int ROW_BYTES    = 4,
   parameter int OFS_W        = 8,
   parameter bit OFS_BY_TABLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ce,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [COORD_W-1:0] spr_top,
   input  logic [COORD_W-1:0] scan_line,
   input  logic               out_ready,
   output logic               out_valid,
   output logic               out_visible,
   output logic [OFS_W-1:0]   out_offset
);

   localparam longint MAX_OFS = longint'(SPR_ROWS - 1) * ROW_BYTES;

   generate
      if (COORD_W < 2) begin : g_bad_coord
         $error("COORD_W must be at least 2");
      end
      if (SPR_ROWS < 1 || SPR_ROWS >= (1 << COORD_W)) begin : g_bad_rows
         $error("SPR_ROWS must lie in 1 .. 2**COORD_W-1");
      end
      if (ROW_BYTES < 1) begin : g_bad_bytes
         $error("ROW_BYTES must be positive");
      end
      if (MAX_OFS >= (longint'(1) << OFS_W)) begin : g_bad_ofs
         $error("largest row offset does not fit OFS_W");
      end
   endgenerate

   logic             s1_ready;
   logic             s1_valid;
   logic [COORD_W:0] s1_diff;
   logic             s2_ready;
   logic             take;

   // A new request only enters when the output side can drain
   assign in_ready = ce && s2_ready;
   assign take     = in_valid && s2_ready;

   vhit_diff_stage #(
      .COORD_W (COORD_W)
   ) u_diff (
      .clk         (clk),
      .rst_n       (rst_n),
      .ce          (ce),
      .take        (take),
      .stage_ready (s1_ready),
      .spr_top     (spr_top),
      .scan_line   (scan_line),
      .diff_valid  (s1_valid),
      .diff        (s1_diff),
      .down_ready  (s2_ready)
   );

   vhit_range_stage #(
      .COORD_W      (COORD_W),
      .SPR_ROWS     (SPR_ROWS),
      .ROW_BYTES    (ROW_BYTES),
      .OFS_W        (OFS_W),
      .OFS_BY_TABLE (OFS_BY_TABLE)
   ) u_range (
      .clk         (clk),
      .rst_n       (rst_n),
      .ce          (ce),
      .diff_valid  (s1_valid),
      .diff        (s1_diff),
      .stage_ready (s2_ready),
      .res_valid   (out_valid),
      .res_visible (out_visible),
      .res_offset  (out_offset),
      .down_ready  (out_ready)
   );

   logic unused_s1_ready;
   assign unused_s1_ready = s1_ready;

endmodule

// File: rtl/sprite_vhit_sva.sv
module sprite_vhit_sva #(
   parameter int COORD_W   = 10,
   parameter int SPR_ROWS  = 16,
   parameter int ROW_BYTES = 4,
   parameter int OFS_W     = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ce,
   input logic               in_valid,
   input logic               in_ready,
   input logic [COORD_W-1:0] spr_top,
   input logic [COORD_W-1:0] scan_line,
   input logic               out_ready,
   input logic               out_valid,
   input logic               out_visible,
   input logic [OFS_W-1:0]   out_offset
);

   localparam int MAX_OFS = (SPR_ROWS - 1) * ROW_BYTES;

   // R4
   hidden_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_visible |-> out_offset == '0);

   // R3
   offset_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_visible |->
         (int'(out_offset) % ROW_BYTES == 0) && (int'(out_offset) <= MAX_OFS));

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !(out_ready && ce) |=>
         out_valid && $stable(out_visible) && $stable(out_offset));

   // R7
   backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   // R8
   ce_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |-> !in_ready);

   // R8
   ce_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(out_valid) && $stable(out_visible) && $stable(out_offset));

   logic unused_inputs;
   assign unused_inputs = in_valid ^ (^spr_top) ^ (^scan_line);

endmodule

bind sprite_vhit_check sprite_vhit_sva #(
   .COORD_W   (COORD_W),
   .SPR_ROWS  (SPR_ROWS),
   .ROW_BYTES (ROW_BYTES),
   .OFS_W     (OFS_W)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce          (ce),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .spr_top     (spr_top),
   .scan_line   (scan_line),
   .out_ready   (out_ready),
   .out_valid   (out_valid),
   .out_visible (out_visible),
   .out_offset  (out_offset)
);

// File: tb/vhit_harness.sv
`timescale 1ns/1ps
module vhit_harness #(
   parameter int COORD_W      = 10,
   parameter int SPR_ROWS     = 16,
   parameter int ROW_BYTES    = 4,
   parameter int OFS_W        = 8,
   parameter bit OFS_BY_TABLE = 1'b1,
   parameter bit SWEEP        = 1'b0,
   parameter int NRAND        = 400
) (
   input  logic clk,
   input  logic rst_n,
   output int   n_checks,
   output int   n_fails,
   output logic done
);

   localparam int SPAN  = 1 << COORD_W;
   localparam int NDIR  = 16;
   localparam int TOTAL = SWEEP ? SPAN * SPAN : NDIR + NRAND;

   logic               ce;
   logic               in_valid;
   logic               in_ready;
   logic [COORD_W-1:0] spr_top;
   logic [COORD_W-1:0] scan_line;
   logic               out_ready;
   logic               out_valid;
   logic               out_visible;
   logic [OFS_W-1:0]   out_offset;

   sprite_vhit_check #(
      .COORD_W      (COORD_W),
      .SPR_ROWS     (SPR_ROWS),
      .ROW_BYTES    (ROW_BYTES),
      .OFS_W        (OFS_W),
      .OFS_BY_TABLE (OFS_BY_TABLE)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ce          (ce),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .spr_top     (spr_top),
      .scan_line   (scan_line),
      .out_ready   (out_ready),
      .out_valid   (out_valid),
      .out_visible (out_visible),
      .out_offset  (out_offset)
   );

   typedef struct {
      int line;
      int top;
      bit vis;
      int ofs;
   } exp_t;

   exp_t expq[$];

   function automatic exp_t model(input int line, input int top);
      exp_t e;
      e.line = line;
      e.top  = top;
      e.vis  = (line >= top) && (line - top < SPR_ROWS);
      e.ofs  = e.vis ? (line - top) * ROW_BYTES : 0;
      return e;
   endfunction

   // Edge coordinates for the wide configuration (line, top)
   task automatic pick(input int idx, output int line, output int top);
      if (SWEEP) begin
         top  = idx / SPAN;
         line = idx % SPAN;
      end else if (idx < NDIR) begin
         case (idx)
            0:  begin line = 10;   top = 10;   end
            1:  begin line = 25;   top = 10;   end
            2:  begin line = 26;   top = 10;   end
            3:  begin line = 9;    top = 10;   end
            4:  begin line = 15;   top = 0;    end
            5:  begin line = 31;   top = 16;   end
            6:  begin line = 32;   top = 16;   end
            7:  begin line = 0;    top = 0;    end
            8:  begin line = 16;   top = 0;    end
            9:  begin line = 0;    top = 1;    end
            10: begin line = 1023; top = 1008; end
            11: begin line = 1023; top = 1007; end
            12: begin line = 1007; top = 1007; end
            13: begin line = 1009; top = 1008; end
            14: begin line = 1023; top = 0;    end
            default: begin line = 0; top = 1023; end
         endcase
         line = line % SPAN;
         top  = top % SPAN;
      end else begin
         top  = int'($urandom % SPAN);
         line = (top + int'($urandom % (SPR_ROWS + 8)) - 4 + SPAN) % SPAN;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   initial begin
      int   sent;
      int   rcvd;
      int   line;
      int   top;
      bit   acc;
      bit   snap;
      bit   snap_v;
      bit   snap_vis;
      int   snap_ofs;
      exp_t e;
      n_checks  = 0;
      n_fails   = 0;
      done      = 1'b0;
      ce        = 1'b1;
      in_valid  = 1'b0;
      out_ready = 1'b0;
      spr_top   = '0;
      scan_line = '0;
      sent = 0; rcvd = 0; acc = 0; snap = 0;
      snap_v = 0; snap_vis = 0; snap_ofs = 0;
      @(negedge clk);
      @(negedge clk);
      #1;
      // R9 reset state
      check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
      check(in_ready == 1'b1, "R9", "in_ready in reset", int'(in_ready), 1);
      @(posedge rst_n);
      while (rcvd < TOTAL) begin
         @(negedge clk);
         if (snap) begin
            // R6 / R8: stalled or frozen outputs hold
            check(out_valid == snap_v, "R6", "held out_valid", int'(out_valid), int'(snap_v));
            if (snap_v) begin
               check(out_visible == snap_vis, "R6", "held out_visible",
                     int'(out_visible), int'(snap_vis));
               check(int'(out_offset) == snap_ofs, "R6", "held out_offset",
                     int'(out_offset), snap_ofs);
            end
         end
         if (acc) in_valid = 1'b0;
         acc       = 0;
         ce        = ($urandom % 10) != 0;
         out_ready = ($urandom % 10) < 7;
         if (!in_valid && sent < TOTAL && ($urandom % 4) != 0) begin
            pick(sent, line, top);
            scan_line = COORD_W'(line);
            spr_top   = COORD_W'(top);
            in_valid  = 1'b1;
            sent++;
         end
         #1;
         if (!ce)
            check(!in_ready, "R8", "in_ready with ce low", int'(in_ready), 0);
         if (out_valid && !out_ready)
            check(!in_ready, "R7", "in_ready under backpressure", int'(in_ready), 0);
         if (in_valid && in_ready) begin
            expq.push_back(model(int'(scan_line), int'(spr_top)));
            acc = 1;
         end
         if (out_valid && out_ready && ce) begin
            if (expq.size() == 0) begin
               check(0, "R5", "answer with nothing pending", 1, 0);
            end else begin
               e = expq.pop_front();
               if (e.line < e.top)
                  check(out_visible == e.vis, "R2", $sformatf("visible line=%0d top=%0d", e.line, e.top),
                        int'(out_visible), int'(e.vis));
               else
                  check(out_visible == e.vis, "R1", $sformatf("visible line=%0d top=%0d", e.line, e.top),
                        int'(out_visible), int'(e.vis));
               if (e.vis)
                  check(int'(out_offset) == e.ofs, "R3", $sformatf("offset line=%0d top=%0d", e.line, e.top),
                        int'(out_offset), e.ofs);
               else
                  check(int'(out_offset) == 0, "R4", $sformatf("offset line=%0d top=%0d", e.line, e.top),
                        int'(out_offset), 0);
            end
            rcvd++;
         end
         snap     = !ce || (out_valid && !out_ready);
         snap_v   = out_valid;
         snap_vis = out_visible;
         snap_ofs = int'(out_offset);
      end
      @(negedge clk);
      ce = 1'b1;
      out_ready = 1'b1;
      repeat (4) @(negedge clk);
      #1;
      // R5: nothing left over, nothing extra
      check(expq.size() == 0, "R5", "pending after drain", expq.size(), 0);
      check(out_valid == 1'b0, "R5", "extra answer after drain", int'(out_valid), 0);
      done = 1'b1;
   end

endmodule

// File: tb/tb_sprite_vhit_check.sv
`timescale 1ns/1ps
module tb_sprite_vhit_check;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 150000;

   logic clk;
   logic rst_n;
   int   chk_a, fail_a, chk_b, fail_b;
   logic done_a, done_b;

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   initial begin
      rst_n = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   end

   // Small copy: all top/line pairs, odd row count, table path
   vhit_harness #(
      .COORD_W (6), .SPR_ROWS (5), .ROW_BYTES (3), .OFS_W (8),
      .OFS_BY_TABLE (1'b1), .SWEEP (1'b1), .NRAND (0)
   ) h_small (
      .clk (clk), .rst_n (rst_n), .n_checks (chk_a), .n_fails (fail_a), .done (done_a)
   );

   // Default-sized copy: edge coordinates and random pairs, multiply path
   vhit_harness #(
      .COORD_W (10), .SPR_ROWS (16), .ROW_BYTES (4), .OFS_W (8),
      .OFS_BY_TABLE (1'b0), .SWEEP (1'b0), .NRAND (600)
   ) h_wide (
      .clk (clk), .rst_n (rst_n), .n_checks (chk_b), .n_fails (fail_b), .done (done_b)
   );

   initial begin
      int cycles;
      int wd_fail;
      cycles  = 0;
      wd_fail = 0;
      while (!(done_a && done_b) && cycles < WATCHDOG) begin
         @(negedge clk);
         cycles++;
      end
      if (!(done_a && done_b)) begin
         wd_fail = 1;
         $display("FAIL watchdog: actual=%0d cycles expected=below %0d", cycles, WATCHDOG);
      end
      $display("== %0d vectors applied, %0d miscompares ==",
               chk_a + chk_b + wd_fail, fail_a + fail_b + wd_fail);
      $finish;
   end

endmodule